// File: doc/BRIEF.md
# Address Window Access Checker

This block sits beside a memory-mapped bus in front of a flash controller and judges every bus access against a set of programmable address windows. Each window has an inclusive lower and upper bound and two permission bits: one admitting accesses flagged non-secure, one admitting writes. An access that falls inside an enabled window but breaks that window's rules is denied. One cycle after the access is presented, the block raises either a permit or a deny strobe.

The first denied access is latched into a sticky violation record. The record holds the offending address and its attributes: master ID, protection bits, non-secure flag and write flag. Software clears the record by writing one to its status bit. A separate watchdog counts how long a bus access stays outstanding and raises a timeout flag once the programmed limit is exceeded.

Configuration goes through a simple register port. A guard field in the security control register can block non-secure configuration writes or reads. A second guard field is exported unchanged for the serial-clock-domain registers of a neighbouring block.

Top module: `addr_window_guard`

## Requirements
- R1: After a synchronous reset, all of the following are zero: `acc_permit`, `acc_deny`, `viol_info`, `wdog_timeout`, `ser_guard`, and every register (security control reads 0).
- R2: While the global enable (security control bit 31) is clear, every access is permitted and no violation is recorded.
- R3: Window i matches when its enable bit (security control bit 8+i) is set and start <= address <= end, with both bounds inclusive. A disabled window never matches, and an access matching no enabled window is permitted.
- R4: Window control bit 0 admits non-secure accesses and bit 1 admits writes. An access whose deciding window rejects its non-secure flag or its write flag is denied.
- R5: When several enabled windows match, the lowest-numbered window alone decides.
- R6: The first denied access sets a record. Its layout is: bit 31 valid, bits 6:5 master ID, bits 4:2 protection bits, bit 1 non-secure flag, bit 0 write flag, all other bits zero. The record is shown on `viol_info` and at register index 3, and the offending address is at register index 2. Later denials leave the record unchanged while it is valid.
- R7: A permitted write of a word with bit 31 set to register index 3 clears the record and the captured address to zero. A write with bit 31 clear has no effect on them.
- R8: `wdog_timeout` rises on the clock edge that completes more than `limit` consecutive cycles with `acc_pending` high. It falls on the first edge at which `acc_pending` is low. A limit of 0 disables the watchdog.
- R9: Security control bits 3:0 guard this block's registers. With bit 0 set, configuration writes marked non-secure are ignored. With bit 1 set, reads marked non-secure return zero. Bits 7:4 are driven on `ser_guard`.
- R10: The register indices are: 0 security control, 1 watchdog limit (bits 15:0), 2 captured address, 3 violation record, and, for window i, 4+3i start, 5+3i end and 6+3i control (bits 1:0). Read data appears on `cfg_rdata` one cycle after the index is presented.
- R11: `acc_permit` and `acc_deny` are registered. Exactly one of them is high in the cycle after `acc_valid`, and both are low in the cycle after a cycle without `acc_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | AW | Access address |
| acc_mid | input | 2 | Master ID of the access |
| acc_prot | input | 3 | Protection attribute bits |
| acc_nsec | input | 1 | Access is non-secure |
| acc_wr | input | 1 | Access is a write |
| acc_pending | input | 1 | A bus access is outstanding |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_nsec | input | 1 | Configuration access is non-secure |
| cfg_addr | input | RAW | Register index |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Registered read data |
| acc_permit | output | 1 | Access permitted (one cycle after the access) |
| acc_deny | output | 1 | Access denied (one cycle after the access) |
| viol_info | output | 32 | Violation record |
| wdog_timeout | output | 1 | Bus watchdog timeout |
| ser_guard | output | 4 | Register guard field for the serial clock group |

## Verification
The assertions assume the following about the inputs:
- Accesses are single-cycle strobes, so any cycle with `acc_valid` yields exactly one decision on the next cycle.
- `acc_pending` is a level that stays high for as long as an access is outstanding.
- Configuration writes are single-cycle, and their effect is visible at the following edge.

The stimulus follows these assumptions. It drives every input on the falling clock edge and holds each access or write for exactly one cycle. It changes the window registers only while the global enable is clear or no access is in flight.

// File: rtl/awg_pkg.sv
package awg_pkg;
  localparam int REG_SEC   = 0;
  localparam int REG_WDOG  = 1;
  localparam int REG_VADDR = 2;
  localparam int REG_VREC  = 3;
  localparam int REG_WIN0  = 4;
  localparam int SEC_GLOBAL = 31;
  localparam int SEC_WIN_LSB = 8;

  typedef struct packed {
    logic [1:0] mid;
    logic [2:0] prot;
    logic       nsec;
    logic       wr;
  } acc_attr_t;
endpackage

// File: rtl/awg_window.sv
module awg_window #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr,
  input  logic          en,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  input  logic [1:0]    ctl,
  input  logic          nsec,
  input  logic          wr,
  output logic          hit,
  output logic          allow
);
  // inclusive bounds on both ends
  assign hit   = en && (addr >= lo) && (addr <= hi);
  assign allow = (!nsec || ctl[0]) && (!wr || ctl[1]);
endmodule

// File: rtl/awg_regs.sv
module awg_regs
  import awg_pkg::*;
#(
  parameter int AW   = 32,
  parameter int NWIN = 7,
  parameter int WDW  = 16,
  parameter int RAW  = 5
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_we,
  input  logic                     cfg_nsec,
  input  logic [RAW-1:0]           cfg_addr,
  input  logic [31:0]              cfg_wdata,
  input  logic [31:0]              rec_word,
  input  logic [AW-1:0]            rec_addr,
  output logic [31:0]              cfg_rdata,
  output logic                     glob_en,
  output logic [NWIN-1:0]          win_en,
  output logic [NWIN-1:0][AW-1:0]  win_lo,
  output logic [NWIN-1:0][AW-1:0]  win_hi,
  output logic [NWIN-1:0][1:0]     win_ctl,
  output logic [WDW-1:0]           wd_limit,
  output logic [3:0]               ser_guard,
  output logic                     rec_clr
);
  localparam logic [31:0] SEC_MASK = (32'h1 << SEC_GLOBAL)
                                   | (((32'h1 << NWIN) - 32'h1) << SEC_WIN_LSB)
                                   | 32'h0000_00FF;

  logic [31:0]             sec_q;
  logic [WDW-1:0]          wd_q;
  logic [NWIN-1:0][AW-1:0] lo_q, hi_q;
  logic [NWIN-1:0][1:0]    ctl_q;
  logic [31:0]             rd_mux;
  logic                    wr_ok, rd_ok;

  assign wr_ok = cfg_we && !(cfg_nsec && sec_q[0]);
  assign rd_ok = !(cfg_nsec && sec_q[1]);

  assign glob_en   = sec_q[SEC_GLOBAL];
  assign win_en    = sec_q[SEC_WIN_LSB +: NWIN];
  assign ser_guard = sec_q[7:4];
  assign win_lo    = lo_q;
  assign win_hi    = hi_q;
  assign win_ctl   = ctl_q;
  assign wd_limit  = wd_q;
  assign rec_clr   = wr_ok && (cfg_addr == RAW'(REG_VREC)) && cfg_wdata[31];

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_q <= '0;
      wd_q  <= '0;
      lo_q  <= '0;
      hi_q  <= '0;
      ctl_q <= '0;
    end else if (wr_ok) begin
      if (cfg_addr == RAW'(REG_SEC))  sec_q <= cfg_wdata & SEC_MASK;
      if (cfg_addr == RAW'(REG_WDOG)) wd_q  <= cfg_wdata[WDW-1:0];
      for (int i = 0; i < NWIN; i++) begin
        if (cfg_addr == RAW'(REG_WIN0 + 3*i))     lo_q[i]  <= cfg_wdata[AW-1:0];
        if (cfg_addr == RAW'(REG_WIN0 + 3*i + 1)) hi_q[i]  <= cfg_wdata[AW-1:0];
        if (cfg_addr == RAW'(REG_WIN0 + 3*i + 2)) ctl_q[i] <= cfg_wdata[1:0];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (cfg_addr == RAW'(REG_SEC))   rd_mux = sec_q;
    if (cfg_addr == RAW'(REG_WDOG))  rd_mux = 32'(wd_q);
    if (cfg_addr == RAW'(REG_VADDR)) rd_mux = 32'(rec_addr);
    if (cfg_addr == RAW'(REG_VREC))  rd_mux = rec_word;
    for (int i = 0; i < NWIN; i++) begin
      if (cfg_addr == RAW'(REG_WIN0 + 3*i))     rd_mux = 32'(lo_q[i]);
      if (cfg_addr == RAW'(REG_WIN0 + 3*i + 1)) rd_mux = 32'(hi_q[i]);
      if (cfg_addr == RAW'(REG_WIN0 + 3*i + 2)) rd_mux = 32'(ctl_q[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= '0;
    else     cfg_rdata <= rd_ok ? rd_mux : 32'h0;
  end

  AST_GUARD_BLOCKS_NS_WRITE: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_nsec && sec_q[0] && cfg_addr == RAW'(REG_SEC)) |=> $stable(sec_q)); // R9
  AST_GUARD_BLOCKS_NS_READ: assert property (@(posedge clk) disable iff (rst)
    (cfg_nsec && sec_q[1] && !cfg_we) |=> (cfg_rdata == 32'h0)); // R9
endmodule

// File: rtl/awg_viol.sv
module awg_viol
  import awg_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          capture,
  input  acc_attr_t     attr,
  input  logic [AW-1:0] addr,
  input  logic          clr,
  output logic [31:0]   rec_word,
  output logic [AW-1:0] rec_addr
);
  logic      valid_q;
  acc_attr_t attr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= 1'b0;
      attr_q   <= '0;
      rec_addr <= '0;
    end else begin
      if (clr) begin
        valid_q  <= 1'b0;
        attr_q   <= '0;
        rec_addr <= '0;
      end
      if (capture && (!valid_q || clr)) begin
        valid_q  <= 1'b1;
        attr_q   <= attr;
        rec_addr <= addr;
      end
    end
  end

  assign rec_word = {valid_q, 24'h0, attr_q};

  AST_RECORD_STICKY: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !clr) |=> ($stable(rec_word) && $stable(rec_addr))); // R6
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    (clr && !capture) |=> (rec_word == 32'h0)); // R7
endmodule

// File: rtl/awg_wdog.sv
module awg_wdog #(
  parameter int WDW = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           pending,
  input  logic [WDW-1:0] limit,
  output logic           timeout
);
  logic [WDW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !pending) begin
      cnt     <= '0;
      timeout <= 1'b0;
    end else begin
      if (cnt != '1) cnt <= cnt + 1'b1;
      timeout <= (limit != '0) && (cnt >= limit);
    end
  end

  AST_WDOG_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !pending |=> !timeout); // R8
  AST_WDOG_OFF_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (limit == '0) |=> !timeout); // R8
endmodule

// File: rtl/addr_window_guard.sv
module addr_window_guard
  import awg_pkg::*;
#(
  parameter int AW   = 32,
  parameter int NWIN = 7,
  parameter int WDW  = 16,
  parameter int RAW  = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           acc_valid,
  input  logic [AW-1:0]  acc_addr,
  input  logic [1:0]     acc_mid,
  input  logic [2:0]     acc_prot,
  input  logic           acc_nsec,
  input  logic           acc_wr,
  input  logic           acc_pending,
  input  logic           cfg_we,
  input  logic           cfg_nsec,
  input  logic [RAW-1:0] cfg_addr,
  input  logic [31:0]    cfg_wdata,
  output logic [31:0]    cfg_rdata,
  output logic           acc_permit,
  output logic           acc_deny,
  output logic [31:0]    viol_info,
  output logic           wdog_timeout,
  output logic [3:0]     ser_guard
);
  logic                    glob_en;
  logic [NWIN-1:0]         win_en, hit, allow;
  logic [NWIN-1:0][AW-1:0] win_lo, win_hi;
  logic [NWIN-1:0][1:0]    win_ctl;
  logic [WDW-1:0]          wd_limit;
  logic                    rec_clr;
  logic [AW-1:0]           rec_addr;
  logic                    viol_now, decided, bad;
  acc_attr_t               attr;

  assign attr = '{mid: acc_mid, prot: acc_prot, nsec: acc_nsec, wr: acc_wr};

  awg_regs #(.AW(AW), .NWIN(NWIN), .WDW(WDW), .RAW(RAW)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_nsec(cfg_nsec),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .rec_word(viol_info),
    .rec_addr(rec_addr), .cfg_rdata(cfg_rdata), .glob_en(glob_en),
    .win_en(win_en), .win_lo(win_lo), .win_hi(win_hi), .win_ctl(win_ctl),
    .wd_limit(wd_limit), .ser_guard(ser_guard), .rec_clr(rec_clr)
  );

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    awg_window #(.AW(AW)) u_win (
      .addr(acc_addr), .en(win_en[i]), .lo(win_lo[i]), .hi(win_hi[i]),
      .ctl(win_ctl[i]), .nsec(acc_nsec), .wr(acc_wr),
      .hit(hit[i]), .allow(allow[i])
    );
  end

  // lowest-numbered matching window decides
  always_comb begin
    decided = 1'b0;
    bad     = 1'b0;
    for (int i = 0; i < NWIN; i++) begin
      if (!decided && hit[i]) begin
        decided = 1'b1;
        bad     = !allow[i];
      end
    end
  end

  assign viol_now = glob_en && bad;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_permit <= 1'b0;
      acc_deny   <= 1'b0;
    end else begin
      acc_permit <= acc_valid && !viol_now;
      acc_deny   <= acc_valid && viol_now;
    end
  end

  awg_viol #(.AW(AW)) u_viol (
    .clk(clk), .rst(rst), .capture(acc_valid && viol_now), .attr(attr),
    .addr(acc_addr), .clr(rec_clr), .rec_word(viol_info), .rec_addr(rec_addr)
  );

  awg_wdog #(.WDW(WDW)) u_wdog (
    .clk(clk), .rst(rst), .pending(acc_pending), .limit(wd_limit),
    .timeout(wdog_timeout)
  );

  AST_ONE_DECISION: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> (acc_permit != acc_deny)); // R11
  AST_QUIET_WITHOUT_ACCESS: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> (!acc_permit && !acc_deny)); // R11
  AST_GLOBAL_OFF_PERMITS: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !glob_en) |=> acc_permit); // R2
  AST_NO_HIT_PERMITS: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && hit == '0) |=> acc_permit); // R3
endmodule

// File: tb/addr_window_guard_tb.sv
module addr_window_guard_tb;
  localparam int AW = 32, NWIN = 7, WDW = 16, RAW = 5;
  localparam int NVEC = 11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic acc_valid = 0, acc_nsec = 0, acc_wr = 0, acc_pending = 0;
  logic [AW-1:0] acc_addr = '0;
  logic [1:0] acc_mid = '0;
  logic [2:0] acc_prot = '0;
  logic cfg_we = 0, cfg_nsec = 0;
  logic [RAW-1:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata, viol_info;
  logic acc_permit, acc_deny, wdog_timeout;
  logic [3:0] ser_guard;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  addr_window_guard #(.AW(AW), .NWIN(NWIN), .WDW(WDW), .RAW(RAW)) u_dut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_mid(acc_mid), .acc_prot(acc_prot), .acc_nsec(acc_nsec), .acc_wr(acc_wr),
    .acc_pending(acc_pending), .cfg_we(cfg_we), .cfg_nsec(cfg_nsec),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .acc_permit(acc_permit), .acc_deny(acc_deny), .viol_info(viol_info),
    .wdog_timeout(wdog_timeout), .ser_guard(ser_guard)
  );

  // {address, nsec, wr, expect_deny}
  localparam logic [34:0] VEC [NVEC] = '{
    {32'h0000_1000, 1'b1, 1'b1, 1'b0},  // R3 start inclusive
    {32'h0000_1FFF, 1'b1, 1'b1, 1'b0},  // R3 end inclusive
    {32'h0000_2000, 1'b0, 1'b0, 1'b0},  // R4 secure read ok
    {32'h0000_2000, 1'b1, 1'b0, 1'b1},  // R4 non-secure refused
    {32'h0000_2FFF, 1'b0, 1'b1, 1'b1},  // R4 write refused at end
    {32'h0000_3000, 1'b1, 1'b1, 1'b0},  // R3 past end, no match
    {32'h0000_0FFF, 1'b1, 1'b1, 1'b0},  // R3 below start
    {32'h0000_4000, 1'b1, 1'b0, 1'b0},  // R4 non-secure read ok
    {32'h0000_4FFF, 1'b0, 1'b1, 1'b1},  // R4 write refused
    {32'h0000_6000, 1'b1, 1'b1, 1'b0},  // R3 disabled window
    {32'h0000_1800, 1'b1, 1'b1, 1'b0}   // R5 overlap, window 0 wins
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input int a, input logic [31:0] d, input logic ns);
    @(negedge clk);
    cfg_we = 1; cfg_addr = RAW'(a); cfg_wdata = d; cfg_nsec = ns;
    @(posedge clk); #1;
    cfg_we = 0; cfg_nsec = 0;
  endtask

  task automatic cfg_read(input int a, input logic ns, output logic [31:0] v);
    @(negedge clk);
    cfg_addr = RAW'(a); cfg_nsec = ns;
    @(posedge clk); #1;
    v = cfg_rdata;
    cfg_nsec = 0;
  endtask

  task automatic access(input logic [31:0] a, input logic [1:0] m, input logic [2:0] p,
                        input logic ns, input logic w);
    @(negedge clk);
    acc_valid = 1; acc_addr = a; acc_mid = m; acc_prot = p; acc_nsec = ns; acc_wr = w;
    @(posedge clk); #1;
    acc_valid = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rv, exp_rec, exp_addr;
    bit seen;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1;
    chk("R1 permit", 32'(acc_permit), 0);
    chk("R1 deny", 32'(acc_deny), 0);
    chk("R1 record", viol_info, 0);
    chk("R1 timeout", 32'(wdog_timeout), 0);
    chk("R1 ser_guard", 32'(ser_guard), 0);
    cfg_read(0, 0, rv);
    chk("R1 security reg", rv, 0);

    // program windows with global enable clear
    cfg_write(4, 32'h1000, 0); cfg_write(5, 32'h1FFF, 0); cfg_write(6, 32'h3, 0);
    cfg_write(7, 32'h1800, 0); cfg_write(8, 32'h2FFF, 0); cfg_write(9, 32'h0, 0);
    cfg_write(10, 32'h4000, 0); cfg_write(11, 32'h4FFF, 0); cfg_write(12, 32'h1, 0);
    cfg_write(13, 32'h6000, 0); cfg_write(14, 32'h6FFF, 0); cfg_write(15, 32'h0, 0);
    cfg_read(4, 0, rv);  chk("R10 win0 start", rv, 32'h1000);
    cfg_read(7, 0, rv);  chk("R10 win1 start", rv, 32'h1800);
    cfg_read(12, 0, rv); chk("R10 win2 ctrl", rv, 32'h1);

    cfg_write(0, 32'h0000_0700, 0);
    access(32'h2000, 2'd1, 3'd2, 1, 1);
    chk("R2 permit with global off", 32'(acc_permit), 1);
    chk("R2 no record", viol_info, 0);
    @(posedge clk); #1;
    chk("R11 quiet after idle", 32'({acc_permit, acc_deny}), 0);

    cfg_write(0, 32'h8000_0700, 0);
    seen = 0; exp_rec = 0; exp_addr = 0;
    for (int i = 0; i < NVEC; i++) begin
      logic [1:0] m;
      logic [2:0] p;
      m = 2'(i % 4);
      p = 3'((i * 3) % 8);
      access(VEC[i][34:3], m, p, VEC[i][2], VEC[i][1]);
      chk($sformatf("R3/R4/R5/R11 vector %0d deny", i), 32'(acc_deny), 32'(VEC[i][0]));
      chk($sformatf("R11 vector %0d permit", i), 32'(acc_permit), 32'(!VEC[i][0]));
      if (VEC[i][0] && !seen) begin
        seen = 1;
        exp_rec = 32'h8000_0000 | (32'(m) << 5) | (32'(p) << 2) |
                  (32'(VEC[i][2]) << 1) | 32'(VEC[i][1]);
        exp_addr = VEC[i][34:3];
      end
    end
    chk("R6 sticky record", viol_info, exp_rec);
    cfg_read(3, 0, rv); chk("R6 record reg", rv, exp_rec);
    cfg_read(2, 0, rv); chk("R6 captured address", rv, exp_addr);

    cfg_write(3, 32'h7FFF_FFFF, 0);
    chk("R7 write without bit31 ignored", viol_info, exp_rec);
    cfg_write(3, 32'h8000_0000, 0);
    chk("R7 clear", viol_info, 0);
    cfg_read(2, 0, rv); chk("R7 address cleared", rv, 0);
    access(32'h4FFF, 2'd2, 3'd5, 0, 1);
    chk("R6 new capture after clear", viol_info, 32'h8000_0055);
    cfg_read(2, 0, rv); chk("R6 new address", rv, 32'h4FFF);

    // register guard
    cfg_write(0, 32'h8000_07A1, 0);
    chk("R9 ser_guard", 32'(ser_guard), 32'hA);
    cfg_write(1, 32'h0000_0055, 1);
    cfg_read(1, 0, rv); chk("R9 non-secure write ignored", rv, 0);
    cfg_write(1, 32'h0000_0003, 0);
    cfg_read(1, 0, rv); chk("R9/R10 secure write", rv, 3);
    cfg_write(0, 32'h8000_07A3, 0);
    cfg_read(0, 1, rv); chk("R9 non-secure read zero", rv, 0);
    cfg_read(0, 0, rv); chk("R9 secure read", rv, 32'h8000_07A3);

    // watchdog with limit 3
    @(negedge clk); acc_pending = 1;
    for (int k = 1; k <= 4; k++) begin
      @(posedge clk); #1;
      chk($sformatf("R8 edge %0d", k), 32'(wdog_timeout), (k >= 4) ? 1 : 0);
    end
    @(negedge clk); acc_pending = 0;
    @(posedge clk); #1;
    chk("R8 falls when idle", 32'(wdog_timeout), 0);
    cfg_write(1, 32'h0, 0);
    @(negedge clk); acc_pending = 1;
    repeat (10) @(posedge clk); #1;
    chk("R8 limit zero disables", 32'(wdog_timeout), 0);
    @(negedge clk); acc_pending = 0;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule